// File: doc/BRIEF.md
# Memory-Reference Instruction Execution Sequencer

This block runs the execute phase of the seven memory-reference instructions of a 16-bit accumulator machine. It holds the accumulator (AC), data register (DR), program counter (PC), address register (AR), the carry flag E, a small word memory and a 4-bit timing step counter. When it is idle and sees a start pulse with a memory-reference opcode and an effective address, it loads the address into AR and jumps the step counter to T4. It then walks T4, T5 and T6 as the instruction needs, asserting memory read and write strobes and register updates, and clears the step counter in the last step. The instruction fetch, indirect-address resolution, register-reference and I/O instructions sit outside this block. Their effect on AC and PC is stood in for by two preset inputs.

Opcode encoding on `op_i`: 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ, 7 not a memory-reference instruction. The step counter reads 0 when idle and 4, 5 or 6 while executing.

Top module: `mri_exec_seq`

## Requirements
- R1: While `rst_ni` is low, `sc_o`, `pc_o`, `ac_o`, `dr_o`, `ar_o` and `e_o` are all zero and `busy_o` is low.
- R2: When idle (`sc_o` = 0), a `start_i` pulse with `op_i` in 0..6 loads AR from `addr_i` and sets `sc_o` to 4 on the next edge. `start_i` while busy has no effect.
- R3: AND (0) reads M[AR] into DR at T4 and sets AC to AC & DR at T5, which ends the instruction.
- R4: ADD (1) reads M[AR] at T4 and at T5 sets AC to the low DW bits of AC + DR and E to the carry-out.
- R5: LDA (2) reads M[AR] at T4 and copies it into AC at T5.
- R6: STA (3) writes AC to M[AR] at T4 and ends there.
- R7: BUN (4) loads PC from AR at T4 and ends there.
- R8: BSA (5) writes PC (zero-extended) to M[AR] and increments AR at T4. At T5 it loads PC from AR, so PC = address + 1 modulo 2^AW.
- R9: ISZ (6) reads M[AR] at T4, increments DR at T5, and at T6 writes DR back to M[AR] and increments PC if DR is zero.
- R10: `mem_rd_o` is high only in T4 of AND, ADD, LDA and ISZ. `mem_wr_o` is high only in T4 of STA and BSA and in T6 of ISZ. The two strobes are never high together.
- R11: `done_o` is high for exactly one step per instruction, its last one, and `sc_o` is 0 on the following edge. Busy lasts 1 step for STA and BUN, 2 for AND, ADD, LDA and BSA, and 3 for ISZ.
- R12: `ld_ac_i` (AC from `ld_val_i`) and `ld_pc_i` (PC from `addr_i`) take effect only when idle and are ignored while busy.
- R13: `start_i` with `op_i` = 7 leaves `sc_o` at 0 and changes no register or memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin execute of the presented instruction |
| op_i | input | 3 | Opcode, decoded 3-to-8 |
| addr_i | input | AW | Effective address; also PC preset value |
| ld_ac_i | input | 1 | Preset AC from ld_val_i when idle |
| ld_pc_i | input | 1 | Preset PC from addr_i when idle |
| ld_val_i | input | DW | AC preset value |
| busy_o | output | 1 | Execute phase in progress |
| sc_o | output | 4 | Timing step counter |
| done_o | output | 1 | Last step of the instruction |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| ac_o | output | DW | Accumulator |
| dr_o | output | DW | Data register |
| pc_o | output | AW | Program counter |
| ar_o | output | AW | Address register |
| e_o | output | 1 | Carry flag |

## Verification
The bench builds the block with AW = 8 and DW = 16. The smaller memory of 256 words lets the bench write every word to a known value with STA before random traffic starts. The top address 255 is then cheap to hit, which exercises the PC wrap to 0 on BSA. Eight address bits still allow the subroutine case with return address 21 saved at location 135. A 16-bit data word keeps the ADD carry into E and the ISZ rollover from 0xFFFF to 0, with its skip, at full machine width.

// File: rtl/mri_pkg.sv
package mri_pkg;
  localparam int unsigned SC_W = 4;
  localparam int unsigned OP_W = 3;
  localparam logic [SC_W-1:0] SC_EXEC = 4'd4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0, OP_ADD = 3'd1, OP_LDA = 3'd2, OP_STA = 3'd3,
    OP_BUN = 3'd4, OP_BSA = 3'd5, OP_ISZ = 3'd6, OP_REG = 3'd7
  } op_e;

  typedef enum logic [1:0] {AC_HOLD, AC_AND, AC_ADD, AC_LOAD} ac_op_e;
  typedef enum logic [1:0] {WS_AC, WS_PC, WS_DR} wsel_e;

  typedef struct packed {
    logic   mem_rd;
    logic   mem_wr;
    wsel_e  wsel;
    logic   dr_ld;
    logic   dr_inr;
    logic   ar_inr;
    logic   pc_ld;
    logic   pc_inr;
    ac_op_e ac_op;
    logic   sc_inr;
    logic   sc_clr;
  } ctl_t;
endpackage

// File: rtl/mri_decode.sv
module mri_decode #(
  parameter int unsigned IN_W  = 3,
  parameter int unsigned OUT_N = 8
) (
  input  logic            en_i,
  input  logic [IN_W-1:0] sel_i,
  output logic [OUT_N-1:0] dec_o
);
  for (genvar g = 0; g < OUT_N; g++) begin : g_line
    assign dec_o[g] = en_i && (sel_i == IN_W'(g));
  end
endmodule

// File: rtl/mri_ctrl.sv
module mri_ctrl
  import mri_pkg::*;
(
  input  logic [6:0] d_i,
  input  logic [6:0] t_i,
  input  logic       dr_zero_i,
  output ctl_t       ctl_o
);
  logic rd_class;
  assign rd_class = d_i[0] | d_i[1] | d_i[2] | d_i[6];

  always_comb begin
    ctl_o = '0;
    // T4: operand fetch or single-step ops
    if (t_i[4]) begin
      if (rd_class) begin
        ctl_o.mem_rd = 1'b1;
        ctl_o.dr_ld  = 1'b1;
        ctl_o.sc_inr = 1'b1;
      end
      if (d_i[3]) begin
        ctl_o.mem_wr = 1'b1;
        ctl_o.wsel   = WS_AC;
        ctl_o.sc_clr = 1'b1;
      end
      if (d_i[4]) begin
        ctl_o.pc_ld  = 1'b1;
        ctl_o.sc_clr = 1'b1;
      end
      if (d_i[5]) begin
        ctl_o.mem_wr = 1'b1;
        ctl_o.wsel   = WS_PC;
        ctl_o.ar_inr = 1'b1;
        ctl_o.sc_inr = 1'b1;
      end
    end
    if (t_i[5]) begin
      if (d_i[0]) ctl_o.ac_op = AC_AND;
      if (d_i[1]) ctl_o.ac_op = AC_ADD;
      if (d_i[2]) ctl_o.ac_op = AC_LOAD;
      if (d_i[0] | d_i[1] | d_i[2]) ctl_o.sc_clr = 1'b1;
      if (d_i[5]) begin
        ctl_o.pc_ld  = 1'b1;
        ctl_o.sc_clr = 1'b1;
      end
      if (d_i[6]) begin
        ctl_o.dr_inr = 1'b1;
        ctl_o.sc_inr = 1'b1;
      end
    end
    // T6: ISZ write-back and skip
    if (t_i[6] && d_i[6]) begin
      ctl_o.mem_wr = 1'b1;
      ctl_o.wsel   = WS_DR;
      ctl_o.pc_inr = dr_zero_i;
      ctl_o.sc_clr = 1'b1;
    end
  end
endmodule

// File: rtl/mri_alu.sv
module mri_alu
  import mri_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  ac_op_e        op_i,
  input  logic [DW-1:0] ac_i,
  input  logic [DW-1:0] dr_i,
  output logic [DW-1:0] ac_o,
  output logic          ac_we_o,
  output logic          e_o,
  output logic          e_we_o
);
  logic [DW:0] sum;
  assign sum = {1'b0, ac_i} + {1'b0, dr_i};

  always_comb begin
    ac_o    = ac_i;
    ac_we_o = 1'b1;
    e_o     = sum[DW];
    e_we_o  = 1'b0;
    unique case (op_i)
      AC_AND:  ac_o = ac_i & dr_i;
      AC_ADD:  begin ac_o = sum[DW-1:0]; e_we_o = 1'b1; end
      AC_LOAD: ac_o = dr_i;
      default: ac_we_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mri_mem.sv
module mri_mem #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end
  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mri_exec_seq.sv
module mri_exec_seq
  import mri_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ld_ac_i,
  input  logic          ld_pc_i,
  input  logic [DW-1:0] ld_val_i,
  output logic          busy_o,
  output logic [3:0]    sc_o,
  output logic          done_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] ac_o,
  output logic [DW-1:0] dr_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] ar_o,
  output logic          e_o
);
  localparam int unsigned N_OP = 7;
  localparam int unsigned N_T  = 7;

  logic [SC_W-1:0] sc_q;
  logic [OP_W-1:0] ir_q;
  logic [AW-1:0]   ar_q, pc_q;
  logic [DW-1:0]   ac_q, dr_q, mem_rdata, mem_wdata, alu_ac;
  logic            e_q, alu_e, alu_ac_we, alu_e_we, idle, accept;
  logic [N_OP-1:0] d;
  logic [N_T-1:0]  t;
  ctl_t            ctl;

  assign idle   = (sc_q == '0);
  assign accept = idle && start_i && (op_i != OP_REG);

  mri_decode #(.IN_W(OP_W), .OUT_N(N_OP)) u_op_dec (
    .en_i(!idle), .sel_i(ir_q), .dec_o(d)
  );
  mri_decode #(.IN_W(SC_W), .OUT_N(N_T)) u_t_dec (
    .en_i(1'b1), .sel_i(sc_q), .dec_o(t)
  );

  mri_ctrl u_ctrl (
    .d_i(d), .t_i(t), .dr_zero_i(dr_q == '0), .ctl_o(ctl)
  );

  mri_alu #(.DW(DW)) u_alu (
    .op_i(ctl.ac_op), .ac_i(ac_q), .dr_i(dr_q),
    .ac_o(alu_ac), .ac_we_o(alu_ac_we), .e_o(alu_e), .e_we_o(alu_e_we)
  );

  always_comb begin
    unique case (ctl.wsel)
      WS_PC:   mem_wdata = DW'(pc_q);
      WS_DR:   mem_wdata = dr_q;
      default: mem_wdata = ac_q;
    endcase
  end

  mri_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i(clk_i), .we_i(ctl.mem_wr), .addr_i(ar_q),
    .wdata_i(mem_wdata), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_q <= '0;
      ir_q <= '0;
      ar_q <= '0;
      pc_q <= '0;
      dr_q <= '0;
      ac_q <= '0;
      e_q  <= 1'b0;
    end else begin
      if (ctl.sc_clr)      sc_q <= '0;
      else if (ctl.sc_inr) sc_q <= sc_q + 1'b1;
      else if (accept)     sc_q <= SC_EXEC;

      if (accept) begin
        ir_q <= op_i;
        ar_q <= addr_i;
      end else if (ctl.ar_inr) begin
        ar_q <= ar_q + 1'b1;
      end

      if (ctl.pc_ld)             pc_q <= ar_q;
      else if (ctl.pc_inr)       pc_q <= pc_q + 1'b1;
      else if (idle && ld_pc_i)  pc_q <= addr_i;

      if (ctl.dr_ld)       dr_q <= mem_rdata;
      else if (ctl.dr_inr) dr_q <= dr_q + 1'b1;

      if (alu_ac_we)            ac_q <= alu_ac;
      else if (idle && ld_ac_i) ac_q <= ld_val_i;

      if (alu_e_we) e_q <= alu_e;
    end
  end

  assign busy_o   = !idle;
  assign sc_o     = sc_q;
  assign done_o   = ctl.sc_clr;
  assign mem_rd_o = ctl.mem_rd;
  assign mem_wr_o = ctl.mem_wr;
  assign ac_o     = ac_q;
  assign dr_o     = dr_q;
  assign pc_o     = pc_q;
  assign ar_o     = ar_q;
  assign e_o      = e_q;
endmodule

// File: rtl/mri_exec_seq_chk.sv
module mri_exec_seq_chk #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [2:0]    op_i,
  input logic [AW-1:0] addr_i,
  input logic          ld_ac_i,
  input logic          ld_pc_i,
  input logic [3:0]    sc_o,
  input logic          done_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [DW-1:0] ac_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] ar_o
);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_o == 4'd0 && start_i && op_i != 3'd7) |=> (sc_o == 4'd4 && ar_o == $past(addr_i)));

  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_rd_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> sc_o == 4'd4);

  p_wr_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (sc_o == 4'd4 || sc_o == 4'd6));

  p_sc_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_o == 4'd0 || (sc_o >= 4'd4 && sc_o <= 4'd6)));

  p_done_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> sc_o == 4'd0);

  p_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_o != 4'd0 && !done_o) |=> sc_o == $past(sc_o) + 4'd1);

  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_o == 4'd0 && !ld_ac_i && !ld_pc_i) |=> ($stable(ac_o) && $stable(pc_o)));

  p_reg_op_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_o == 4'd0 && start_i && op_i == 3'd7) |=> (sc_o == 4'd0 && $stable(ar_o)));
endmodule

bind mri_exec_seq mri_exec_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_mri_exec_seq.sv
`timescale 1ns/1ps
module sim_mri_exec_seq;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 16;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [2:0]    op_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic          ld_ac_i = 1'b0;
  logic          ld_pc_i = 1'b0;
  logic [DW-1:0] ld_val_i = '0;
  logic          busy_o, done_o, mem_rd_o, mem_wr_o, e_o;
  logic [3:0]    sc_o;
  logic [DW-1:0] ac_o, dr_o;
  logic [AW-1:0] pc_o, ar_o;

  always #2.5 clk_i = ~clk_i;

  mri_exec_seq #(.AW(AW), .DW(DW)) u0 (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_ac = '0;
  logic [AW-1:0] m_pc = '0;
  logic          m_e  = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_steps(input logic [2:0] op);
    case (op)
      3'd3, 3'd4: return 1;
      3'd6:       return 3;
      3'd7:       return 0;
      default:    return 2;
    endcase
  endfunction

  function automatic int exp_rd(input logic [2:0] op);
    return (op <= 3'd2 || op == 3'd6) ? 1 : 0;
  endfunction

  function automatic int exp_wr(input logic [2:0] op);
    return (op == 3'd3 || op == 3'd5 || op == 3'd6) ? 1 : 0;
  endfunction

  task automatic model(input logic [2:0] op, input logic [AW-1:0] ea);
    logic [DW:0] s;
    case (op)
      3'd0: m_ac = m_ac & m_mem[ea];
      3'd1: begin s = {1'b0, m_ac} + {1'b0, m_mem[ea]}; m_ac = s[DW-1:0]; m_e = s[DW]; end
      3'd2: m_ac = m_mem[ea];
      3'd3: m_mem[ea] = m_ac;
      3'd4: m_pc = ea;
      3'd5: begin m_mem[ea] = DW'(m_pc); m_pc = ea + 1'b1; end
      3'd6: begin m_mem[ea] = m_mem[ea] + 1'b1; if (m_mem[ea] == '0) m_pc = m_pc + 1'b1; end
      default: ;
    endcase
  endtask

  task automatic preset_ac(input logic [DW-1:0] v);
    @(negedge clk_i); ld_ac_i = 1'b1; ld_val_i = v;
    @(negedge clk_i); ld_ac_i = 1'b0;
    m_ac = v;
  endtask

  task automatic preset_pc(input logic [AW-1:0] v);
    @(negedge clk_i); ld_pc_i = 1'b1; addr_i = v;
    @(negedge clk_i); ld_pc_i = 1'b0;
    m_pc = v;
  endtask

  // poke: drive start and both presets during the first busy step
  task automatic exec(input logic [2:0] op, input logic [AW-1:0] ea, input bit poke);
    int steps = 0, rd = 0, wr = 0, dn = 0;
    @(negedge clk_i); start_i = 1'b1; op_i = op; addr_i = ea;
    @(negedge clk_i); start_i = 1'b0;
    while (busy_o && steps < 8) begin
      steps++;
      rd += int'(mem_rd_o); wr += int'(mem_wr_o); dn += int'(done_o);
      if (steps == 1) begin
        chk("R2 ar", 32'(ar_o), 32'(ea));
        chk("R2 sc", 32'(sc_o), 32'd4);
        if (poke) begin
          start_i = 1'b1; op_i = 3'd4; addr_i = ~ea;
          ld_ac_i = 1'b1; ld_val_i = ~m_ac; ld_pc_i = 1'b1;
        end
      end
      @(negedge clk_i);
      start_i = 1'b0; ld_ac_i = 1'b0; ld_pc_i = 1'b0;
    end
    model(op, ea);
    chk("R11 steps", 32'(steps), 32'(exp_steps(op)));
    chk("R11 done", 32'(dn), (op == 3'd7) ? 32'd0 : 32'd1);
    chk("R10 rd", 32'(rd), 32'(exp_rd(op)));
    chk("R10 wr", 32'(wr), 32'(exp_wr(op)));
    case (op)
      3'd0: chk("R3 ac", 32'(ac_o), 32'(m_ac));
      3'd1: begin chk("R4 ac", 32'(ac_o), 32'(m_ac)); chk("R4 e", 32'(e_o), 32'(m_e)); end
      3'd2: chk("R5 ac", 32'(ac_o), 32'(m_ac));
      3'd4: chk("R7 pc", 32'(pc_o), 32'(m_pc));
      3'd5: chk("R8 pc", 32'(pc_o), 32'(m_pc));
      3'd6: chk("R9 pc", 32'(pc_o), 32'(m_pc));
      3'd7: begin
        chk("R13 sc", 32'(sc_o), 32'd0);
        chk("R13 ac", 32'(ac_o), 32'(m_ac));
        chk("R13 pc", 32'(pc_o), 32'(m_pc));
      end
      default: ;
    endcase
    if (poke) begin
      chk("R12 ac", 32'(ac_o), 32'(m_ac));
      chk("R12 pc", 32'(pc_o), 32'(m_pc));
    end
  endtask

  // read a word back through LDA and compare with the model
  task automatic peek(input string req, input logic [AW-1:0] ea);
    logic [DW-1:0] want;
    want = m_mem[ea];
    exec(3'd2, ea, 1'b0);
    chk(req, 32'(ac_o), 32'(want));
  endtask

  initial begin
    void'($urandom(32'h1bad_5eed));
    repeat (3) @(negedge clk_i);
    chk("R1 sc", 32'(sc_o), 32'd0);
    chk("R1 pc", 32'(pc_o), 32'd0);
    chk("R1 ac", 32'(ac_o), 32'd0);
    chk("R1 dr", 32'(dr_o), 32'd0);
    chk("R1 ar", 32'(ar_o), 32'd0);
    chk("R1 e", 32'(e_o), 32'd0);
    chk("R1 busy", 32'(busy_o), 32'd0);
    rst_ni = 1'b1;

    // fill memory through STA (R6)
    for (int a = 0; a < int'(DEPTH); a++) begin
      preset_ac(DW'($urandom));
      exec(3'd3, AW'(a), 1'b0);
    end
    peek("R6 mem", 8'd7);

    // directed: subroutine call at 135 from return address 21
    preset_pc(8'd21);
    exec(3'd5, 8'd135, 1'b0);
    chk("R8 pc136", 32'(pc_o), 32'd136);
    peek("R8 ret21", 8'd135);

    // BSA at the top address wraps PC
    exec(3'd5, 8'd255, 1'b0);
    chk("R8 wrap", 32'(pc_o), 32'd0);

    // ADD with carry out
    preset_ac(16'hFFFF);
    preset_ac(16'h0001); exec(3'd3, 8'd40, 1'b0);
    preset_ac(16'hFFFF); exec(3'd1, 8'd40, 1'b0);
    chk("R4 carry", 32'(e_o), 32'd1);
    chk("R4 sum", 32'(ac_o), 32'd0);

    // ISZ rollover skips, non-zero does not
    preset_pc(8'd50);
    preset_ac(16'hFFFF); exec(3'd3, 8'd41, 1'b0);
    exec(3'd6, 8'd41, 1'b0);
    chk("R9 skip", 32'(pc_o), 32'd51);
    peek("R9 zero", 8'd41);
    exec(3'd6, 8'd41, 1'b0);
    chk("R9 noskip", 32'(pc_o), 32'd51);
    peek("R9 one", 8'd41);

    // BUN, busy pokes and op 7
    exec(3'd4, 8'd200, 1'b1);
    exec(3'd6, 8'd9, 1'b1);
    exec(3'd7, 8'd77, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      logic [AW-1:0] ea;
      op = 3'($urandom_range(0, 7));
      ea = AW'($urandom);
      if ($urandom_range(0, 7) == 0) preset_ac(DW'($urandom));
      if ($urandom_range(0, 9) == 0) preset_pc(AW'($urandom));
      exec(op, ea, ($urandom_range(0, 3) == 0));
      if (op == 3'd3 || op == 3'd5 || op == 3'd6) peek("R10 mem", ea);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule